// File: doc/BRIEF.md
# Shift-Ring Test Pattern Store

This block is an on-chip store for converter test patterns that contains no addressed RAM. It is built only from shift registers. There are two modes. In load mode every storage flop joins one long serial chain, which is filled one bit per strobe from a slow serial input. In run mode the same flops are regrouped into eight parallel ring slices. Each slice is one word wide and recirculates its contents without end, and it advances only while its own slice enable is high. Each slice is observed at a single fixed tap word. Slice k holds every eighth sample of the pattern, starting at sample k, so an external interleaving stage can rebuild the full-rate stream.

Nothing in the store is addressed. When a slice advances, every word in it moves, so the switching activity is the same whatever the data. Ring length is a parameter, and memory depth is changed by changing it. The default ring length of 104 words gives 832 six-bit samples (4992 bits). All flops run on one common clock, and the mode change is a 2:1 multiplexer in front of each flop.

Top module: `ring_pattern_store`

## Requirements
- R1: A synchronous active-high reset clears every stored bit, so that after reset all of `tap_data` reads zero.
- R2: In load mode (`mode_run`=0), each cycle with `ser_valid`=1 shifts one bit of `ser_din` into the chain. The bits are sent slice 0 first, then slice 1, and so on. Within a slice, words are sent in ring order 0..RING_LEN-1, and each word goes least significant bit first. After SLICES*RING_LEN*WORD_W bits, word j of slice k holds sample 8j+k, and the tap of slice k (`tap_data[k*WORD_W +: WORD_W]`) shows sample k.
- R3: In load mode, a cycle with `ser_valid`=0 changes no stored bit, whatever the value of `ser_din`.
- R4: In run mode (`mode_run`=1), each cycle with `slice_en[k]`=1 moves the tap of slice k to the next stored word of that slice. After RING_LEN such advances the slice returns to the word it started from.
- R5: In run mode each slice advances only on its own enable, independently of the other slices.
- R6: Toggling `mode_run` while all slice enables are low and `ser_valid` is low leaves every stored word unchanged.
- R7: In run mode, `ser_valid` and `ser_din` have no effect on the stored contents.
- R8: In load mode, `slice_en` has no effect. All slices shift together, and only on `ser_valid`.
- R9: Shifting WORD_W further bits in load mode moves the tap of every slice to the word that followed it in that slice.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock for all storage |
| rst | input | 1 | Synchronous active-high reset |
| ser_din | input | 1 | Serial upload data bit |
| ser_valid | input | 1 | Upload strobe: shift the chain one bit this cycle |
| mode_run | input | 1 | 0 = load (serial chain), 1 = run (ring slices) |
| slice_en | input | SLICES (8) | Per-slice advance enable in run mode |
| tap_data | output | SLICES*WORD_W (48) | Fixed-tap word of each slice; slice k at bits k*WORD_W upward |

## Verification
The assertions assume that the mode select is only changed during a cycle in which no slice advances and no serial strobe is present. They also assume that reset is held for at least one clock edge before any use. The bench keeps to these assumptions: every mode change is made in a step with all enables low and the strobe low, and a load is started only after a quiet cycle. Within that envelope the bench still drives illegal-looking traffic to confirm that it is ignored. It holds serial data and strobes active during run mode, sets enables during load, and toggles data during strobe gaps.

// File: rtl/ring_store_pkg.sv
package ring_store_pkg;

    localparam int DEF_SLICES   = 8;
    localparam int DEF_WORD_W   = 6;
    localparam int DEF_RING_LEN = 104;

    typedef enum logic {
        MODE_LOAD = 1'b0,
        MODE_RUN  = 1'b1
    } ring_mode_e;

    function automatic int ring_bits(input int ring_len, input int word_w);
        return ring_len * word_w;
    endfunction

endpackage

// File: rtl/ring_shift_ctrl.sv
module ring_shift_ctrl
    import ring_store_pkg::*;
#(
    parameter int SLICES = DEF_SLICES
) (
    input  logic              clk,
    input  logic              rst,
    input  ring_mode_e        mode,
    input  logic              ser_valid,
    input  logic [SLICES-1:0] slice_en,
    output logic [SLICES-1:0] advance
);

    always_comb begin
        if (mode == MODE_RUN) begin
            advance = slice_en;
        end else begin
            advance = {SLICES{ser_valid}};
        end
    end

    // R8: while loading, the whole chain moves as one
    assert_load_lockstep_R8: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_LOAD) |-> (advance == '0 || advance == '1));

    // R5: a ring may only advance when its own enable is set
    assert_run_gate_R5: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_RUN) |-> ((advance & ~slice_en) == '0));

    // R7: serial strobe has no say in run mode
    assert_run_no_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_RUN && slice_en == '0) |-> (advance == '0));

endmodule

// File: rtl/ring_slice.sv
module ring_slice
    import ring_store_pkg::*;
#(
    parameter int WORD_W   = DEF_WORD_W,
    parameter int RING_LEN = DEF_RING_LEN
) (
    input  logic              clk,
    input  logic              rst,
    input  ring_mode_e        mode,
    input  logic              advance,
    input  logic              chain_in,
    output logic              chain_out,
    output logic [WORD_W-1:0] tap
);

    localparam int NBITS = ring_bits(RING_LEN, WORD_W);

    logic [NBITS-1:0] bits_q;
    logic [NBITS-1:0] bits_d;

    // 2:1 selection per flop: ring feedback (run) or serial link (load)
    always_comb begin
        if (mode == MODE_RUN) begin
            bits_d = {bits_q[WORD_W-1:0], bits_q[NBITS-1:WORD_W]};
        end else begin
            bits_d = {chain_in, bits_q[NBITS-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bits_q <= '0;
        end else if (advance) begin
            bits_q <= bits_d;
        end
    end

    assign tap       = bits_q[WORD_W-1:0];
    assign chain_out = bits_q[0];

    // R3 / R6: no advance, no change anywhere in the ring
    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(bits_q));

    // R4: a run-mode step brings the following word to the tap
    assert_ring_advance_R4: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_RUN && advance) |=> (tap == $past(bits_q[2*WORD_W-1:WORD_W])));

    // R4: the word leaving the tap re-enters at the far end
    assert_ring_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_RUN && advance) |=> (bits_q[NBITS-1:NBITS-WORD_W] == $past(tap)));

    // R2: a load-mode step takes the incoming link bit at the far end
    assert_chain_entry_R2: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_LOAD && advance) |=> (bits_q[NBITS-1] == $past(chain_in)));

endmodule

// File: rtl/ring_pattern_store.sv
module ring_pattern_store
    import ring_store_pkg::*;
#(
    parameter int SLICES   = DEF_SLICES,
    parameter int WORD_W   = DEF_WORD_W,
    parameter int RING_LEN = DEF_RING_LEN
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ser_din,
    input  logic                     ser_valid,
    input  logic                     mode_run,
    input  logic [SLICES-1:0]        slice_en,
    output logic [SLICES*WORD_W-1:0] tap_data
);

    localparam int TAP_W = SLICES * WORD_W;

    ring_mode_e        mode;
    logic [SLICES-1:0] advance;
    logic [SLICES:0]   link;

    assign mode         = mode_run ? MODE_RUN : MODE_LOAD;
    assign link[SLICES] = ser_din;

    ring_shift_ctrl #(
        .SLICES (SLICES)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .ser_valid (ser_valid),
        .slice_en  (slice_en),
        .advance   (advance)
    );

    // Load chain runs from the last slice down to slice 0, whose
    // outgoing bit is discarded.
    for (genvar k = 0; k < SLICES; k++) begin : g_slice
        ring_slice #(
            .WORD_W   (WORD_W),
            .RING_LEN (RING_LEN)
        ) u_slice (
            .clk       (clk),
            .rst       (rst),
            .mode      (mode),
            .advance   (advance[k]),
            .chain_in  (link[k+1]),
            .chain_out (link[k]),
            .tap       (tap_data[k*WORD_W +: WORD_W])
        );
    end

    // R1: reset leaves every tap at zero
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (tap_data == TAP_W'(0)));

    // R6: mode flips with no enable and no strobe keep the contents
    assert_toggle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (slice_en == '0 && !ser_valid) |=> $stable(tap_data));

endmodule

// File: tb/sim_ring_pattern_store.sv
module sim_ring_pattern_store;

    localparam int NS = 8;
    localparam int W  = 6;
    localparam int L  = 104;
    localparam int NV = 8;

    // {slice enable mask, number of cycles}
    localparam logic [15:0] VEC [NV] = '{
        {8'h01, 8'd3}, {8'h80, 8'd5}, {8'h55, 8'd2}, {8'hAA, 8'd7},
        {8'h0F, 8'd1}, {8'hF0, 8'd104}, {8'h3C, 8'd50}, {8'hFF, 8'd9}
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            ser_din = 1'b0;
    logic            ser_valid = 1'b0;
    logic            mode_run = 1'b0;
    logic [NS-1:0]   slice_en = '0;
    logic [NS*W-1:0] tap_data;

    int errors = 0;
    int checks = 0;
    int pos [NS];

    always #10 clk = ~clk;

    ring_pattern_store u0 (
        .clk       (clk),
        .rst       (rst),
        .ser_din   (ser_din),
        .ser_valid (ser_valid),
        .mode_run  (mode_run),
        .slice_en  (slice_en),
        .tap_data  (tap_data)
    );

    function automatic logic [W-1:0] pat(input int n);
        return W'((n * 37 + 11 + (n / 64) * 5) % 64);
    endfunction

    // drive at a falling edge, let one rising edge pass, return at the next falling edge
    task automatic step(input logic [NS-1:0] en, input logic run,
                        input logic valid, input logic din);
        slice_en  = en;
        mode_run  = run;
        ser_valid = valid;
        ser_din   = din;
        @(posedge clk);
        if (run) begin
            for (int k = 0; k < NS; k++)
                if (en[k]) pos[k] = (pos[k] + 1) % L;
        end
        @(negedge clk);
    endtask

    task automatic check_taps(input string req);
        for (int k = 0; k < NS; k++) begin
            logic [W-1:0] exp_w;
            exp_w = pat(NS * pos[k] + k);
            checks++;
            if (tap_data[k*W +: W] !== exp_w) begin
                errors++;
                $display("FAIL %s slice %0d: got %0d expected %0d",
                         req, k, tap_data[k*W +: W], exp_w);
            end
        end
    endtask

    task automatic check_zero(input string req);
        checks++;
        if (tap_data !== '0) begin
            errors++;
            $display("FAIL %s: got %h expected 0", req, tap_data);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int k = 0; k < NS; k++) pos[k] = 0;
        @(negedge clk);
        @(negedge clk);
        check_zero("R1 after reset");
        rst = 1'b0;
        step('0, 1'b0, 1'b0, 1'b0);

        // Full load with strobe gaps (R3) and junk enables (R8)
        for (int s = 0; s < NS; s++) begin
            for (int j = 0; j < L; j++) begin
                for (int b = 0; b < W; b++) begin
                    logic [W-1:0] smp;
                    smp = pat(NS * j + s);
                    if (((s * L + j) * W + b) % 7 == 3)
                        step(8'hA5, 1'b0, 1'b0, ~smp[b]);
                    step(8'h5A, 1'b0, 1'b1, smp[b]);
                end
            end
        end
        step('0, 1'b0, 1'b0, 1'b1);
        check_taps("R2 load order");   // also exercises R3 and R8

        // Mode change with everything idle (R6)
        step('0, 1'b1, 1'b0, 1'b0);
        step('0, 1'b0, 1'b0, 1'b1);
        step('0, 1'b1, 1'b0, 1'b0);
        check_taps("R6 mode toggle");

        // One full revolution of every ring (R4)
        for (int r = 0; r < L; r++) begin
            step('1, 1'b1, 1'b0, 1'b0);
            check_taps("R4 ring step");
        end
        for (int k = 0; k < NS; k++) begin
            checks++;
            if (pos[k] != 0 || tap_data[k*W +: W] !== pat(k)) begin
                errors++;
                $display("FAIL R4 wrap slice %0d: got %0d expected %0d",
                         k, tap_data[k*W +: W], pat(k));
            end
        end

        // Table of per-slice enable patterns (R5)
        for (int v = 0; v < NV; v++) begin
            for (int c = 0; c < int'(VEC[v][7:0]); c++)
                step(VEC[v][15:8], 1'b1, 1'b0, 1'b0);
            check_taps("R5 independent slices");
        end

        // Serial traffic in run mode is ignored (R7)
        for (int c = 0; c < 10; c++)
            step('0, 1'b1, 1'b1, c[0]);
        check_taps("R7 strobe ignored idle");
        for (int c = 0; c < 3; c++)
            step('1, 1'b1, 1'b1, ~c[0]);
        check_taps("R7 strobe ignored running");

        // Word-sized upload pushes each tap to its following word (R9)
        step('0, 1'b0, 1'b0, 1'b0);
        for (int b = 0; b < W; b++)
            step(8'hFF, 1'b0, 1'b1, b[0]);
        for (int k = 0; k < NS; k++) pos[k] = (pos[k] + 1) % L;
        check_taps("R9 chain through taps");

        // Reset in mid-operation clears storage (R1)
        rst = 1'b1;
        step('0, 1'b0, 1'b0, 1'b0);
        rst = 1'b0;
        check_zero("R1 mid-run reset");
        step('1, 1'b1, 1'b0, 1'b0);
        check_zero("R1 rings empty after reset");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule